// File: doc/BRIEF.md
# SPI FIFO Word Packer

This block sits between a 32-bit FIFO word stream and an SPI shift engine that handles words of 4 to 32 bits. On the transmit path it takes FIFO words and splits them into SPI words, handing them to the shifter one at a time. On the receive path it gathers SPI words from the shifter into FIFO words. It also attaches status to each received FIFO word so that the host can work out how many bytes are valid. Each path has ready/valid handshakes on both of its sides. Each transfer is opened with a start pulse that carries its length in SPI words.

When the word length divides 32 exactly, several SPI words share one FIFO word, with the first word in the lowest bits. For any other word length, each SPI word gets a FIFO word of its own, aligned to bit 0. Its byte footprint is then 1, 2 or 4 bytes, and that footprint sets the valid-byte count reported with the final receive word. On both sides, SPI words appear in shift order: bit `word_len-1` is the first bit on the line. A least-significant-first setting mirrors the bits of each word inside its own width.

The transmit controller has three states. `TX_IDLE` moves to `TX_FETCH` on an accepted start. `TX_FETCH` moves to `TX_EMIT` once a FIFO word is taken. `TX_EMIT` stays in `TX_EMIT` to step to the next slot, returns to `TX_FETCH` when the slots of the held word are used up, and returns to `TX_IDLE` after the final SPI word. The receive controller also has three states. `RX_IDLE` moves to `RX_FILL` on an accepted start. `RX_FILL` moves to `RX_FLUSH` when the FIFO word is full or the final SPI word arrives. `RX_FLUSH` goes back to `RX_FILL` after a non-final word is taken, or to `RX_IDLE` after the final one.

Top module: `spi_word_packer`

## Requirements
- R1: When 32 is a multiple of the word length L (L = 4, 8, 16 or 32), each FIFO word carries 32/L SPI words, and SPI word i of that FIFO word sits in bits [i*L +: L].
- R2: For any other L, each FIFO word carries exactly one SPI word in bits [L-1:0]. Every bit of `tx_word` above L-1 is zero, and `rx_word` bits above L-1 are ignored.
- R3: With `cfg_lsb_first`=0, a word's value is passed through unchanged. With it set to 1, bit k of the word in the FIFO word corresponds to bit L-1-k of the word on the shifter side. This holds in both directions.
- R4: A transmit transfer of N words emits exactly N SPI words and raises `tx_word_last` only with the N-th one. It takes exactly the number of FIFO words needed to hold N words, and any unused slots in the final FIFO word are dropped.
- R5: `rx_fifo_last` is 1 only on the final FIFO word of a receive transfer, and `rx_fifo_lbv` is 0 on every other FIFO word.
- R6: On the final receive FIFO word, `rx_fifo_lbv` is the number of valid bytes modulo 4, so 0 means all 4 bytes are valid. In the shared case the valid bytes are ceil(k*L/8) for k words. In the unshared case they are 1 for L of 8 or less, 2 for L from 9 to 16, and 4 above that.
- R7: A partly filled receive FIFO word is flushed at the end of the transfer, with every unused bit zero.
- R8: `rx_fifo_cnt` numbers the FIFO words of a receive transfer from 1 upward.
- R9: A configuration write takes effect only when both paths are idle and the length is between 4 and 32. Any other write is ignored.
- R10: A start pulse with a count of zero, or one that arrives while its path is busy, is ignored.
- R11: While an output valid is high and its ready is low, the valid stays high and the data stays unchanged.
- R12: After reset, all valid and ready outputs are 0, the word length is 8 and bits go most-significant first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_word_len | input | 6 | SPI word length in bits (4..32) |
| cfg_lsb_first | input | 1 | 1 = least significant bit shifted first |
| tx_start | input | 1 | Opens a transmit transfer |
| tx_count | input | LEN_W | Transmit length in SPI words |
| tx_fifo_data | input | 32 | FIFO word to unpack |
| tx_fifo_valid | input | 1 | FIFO word offered |
| tx_fifo_ready | output | 1 | FIFO word taken this cycle if valid |
| tx_word | output | 32 | SPI word in shift order, right-aligned |
| tx_word_valid | output | 1 | SPI word offered |
| tx_word_ready | input | 1 | Shifter takes the SPI word |
| tx_word_last | output | 1 | Final SPI word of the transfer |
| rx_start | input | 1 | Opens a receive transfer |
| rx_count | input | LEN_W | Receive length in SPI words |
| rx_word | input | 32 | Received SPI word in shift order |
| rx_word_valid | input | 1 | Received word offered |
| rx_word_ready | output | 1 | Received word taken if valid |
| rx_fifo_data | output | 32 | Packed FIFO word |
| rx_fifo_valid | output | 1 | FIFO word offered |
| rx_fifo_ready | input | 1 | FIFO accepts the word |
| rx_fifo_last | output | 1 | Final FIFO word of the transfer |
| rx_fifo_lbv | output | 2 | Valid bytes of the final word modulo 4 |
| rx_fifo_cnt | output | LEN_W | FIFO word number within the transfer |

## Verification
The assertions check four things on every cycle. Output data stays frozen during backpressure. Transmit bits above the word length stay zero. Non-final receive words report a valid-byte count of zero. The configuration never moves while either path is busy. What only the bench can show are the values themselves: slot placement and bit mirroring for each word length, the number of FIFO words consumed per transfer, zero fill and byte counts on the final word, and the rejection of late configuration writes or restarts. These are checked against a model rebuilt in the bench from the requirements, under random stalls.

// File: rtl/spw_pkg.sv
package spw_pkg;

    localparam int FW  = 32;
    localparam int WLW = 6;

    typedef enum logic [1:0] {TX_IDLE, TX_FETCH, TX_EMIT} tx_state_e;
    typedef enum logic [1:0] {RX_IDLE, RX_FILL, RX_FLUSH} rx_state_e;

    typedef struct packed {
        logic             shared;
        logic [WLW-1:0]   per;
        logic [1:0]       lane_lbv;
    } geom_t;

    function automatic logic [FW-1:0] wl_mask(input logic [WLW-1:0] wl);
        return {FW{1'b1}} >> (6'd32 - wl);
    endfunction

    function automatic logic [FW-1:0] orient(input logic [FW-1:0] v,
                                             input logic [WLW-1:0] wl,
                                             input logic lsb);
        logic [FW-1:0] r;
        for (int i = 0; i < FW; i++) r[i] = v[FW-1-i];
        return lsb ? (r >> (6'd32 - wl)) : v;
    endfunction

    function automatic geom_t geom_of(input logic [WLW-1:0] wl);
        geom_t g;
        g.shared   = 1'b1;
        g.lane_lbv = 2'd0;
        case (wl)
            6'd4:    g.per = 6'd8;
            6'd8:    g.per = 6'd4;
            6'd16:   g.per = 6'd2;
            6'd32:   g.per = 6'd1;
            default: begin
                g.shared = 1'b0;
                g.per    = 6'd1;
                if (wl <= 6'd8)       g.lane_lbv = 2'd1;
                else if (wl <= 6'd16) g.lane_lbv = 2'd2;
                else                  g.lane_lbv = 2'd0;
            end
        endcase
        return g;
    endfunction

    function automatic logic [1:0] lbv_of_bits(input logic [WLW-1:0] nbits);
        if (nbits <= 6'd8)       return 2'd1;
        else if (nbits <= 6'd16) return 2'd2;
        else if (nbits <= 6'd24) return 2'd3;
        else                     return 2'd0;
    endfunction

endpackage

// File: rtl/spw_cfg.sv
module spw_cfg
    import spw_pkg::*;
#(
    parameter int RST_WL = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic [WLW-1:0]  cfg_word_len,
    input  logic            cfg_lsb_first,
    input  logic            tx_idle,
    input  logic            rx_idle,
    output logic [WLW-1:0]  wl,
    output logic            lsb,
    output logic [FW-1:0]   mask,
    output logic            shared,
    output logic [WLW-1:0]  per,
    output logic [1:0]      lane_lbv
);

    localparam logic [WLW-1:0] RWL = RST_WL[WLW-1:0];

    logic  accept;
    geom_t geom_q;

    assign accept = cfg_wr && tx_idle && rx_idle &&
                    (cfg_word_len >= 6'd4) && (cfg_word_len <= 6'd32);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wl     <= RWL;
            lsb    <= 1'b0;
            mask   <= wl_mask(RWL);
            geom_q <= geom_of(RWL);
        end else if (accept) begin
            wl     <= cfg_word_len;
            lsb    <= cfg_lsb_first;
            mask   <= wl_mask(cfg_word_len);
            geom_q <= geom_of(cfg_word_len);
        end
    end

    assign shared   = geom_q.shared;
    assign per      = geom_q.per;
    assign lane_lbv = geom_q.lane_lbv;

    AST_CFG_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_idle && rx_idle) |=> ($stable(wl) && $stable(lsb))); // R9

    AST_CFG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wl >= 6'd4) && (wl <= 6'd32)); // R9

endmodule

// File: rtl/spw_tx_unpack.sv
module spw_tx_unpack
    import spw_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WLW-1:0]   wl,
    input  logic             lsb,
    input  logic [FW-1:0]    mask,
    input  logic [WLW-1:0]   per,
    input  logic             tx_start,
    input  logic [LEN_W-1:0] tx_count,
    input  logic [FW-1:0]    tx_fifo_data,
    input  logic             tx_fifo_valid,
    output logic             tx_fifo_ready,
    output logic [FW-1:0]    tx_word,
    output logic             tx_word_valid,
    input  logic             tx_word_ready,
    output logic             tx_word_last,
    output logic             idle
);

    tx_state_e        state, state_n;
    logic [FW-1:0]    hold;
    logic [WLW-1:0]   slot;
    logic [LEN_W-1:0] rem;
    logic             take_fifo, give_word, begin_xfer;

    assign begin_xfer = (state == TX_IDLE) && tx_start && (tx_count != '0);
    assign take_fifo  = (state == TX_FETCH) && tx_fifo_valid;
    assign give_word  = (state == TX_EMIT) && tx_word_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            TX_IDLE:  if (begin_xfer) state_n = TX_FETCH;
            TX_FETCH: if (take_fifo)  state_n = TX_EMIT;
            TX_EMIT: begin
                if (give_word) begin
                    if (rem == LEN_W'(1))             state_n = TX_IDLE;
                    else if (slot == per - 6'd1)      state_n = TX_FETCH;
                    else                              state_n = TX_EMIT;
                end
            end
            default:  state_n = TX_IDLE;
        endcase
    end

    always_comb begin
        tx_fifo_ready = (state == TX_FETCH);
        tx_word_valid = (state == TX_EMIT);
        tx_word_last  = (state == TX_EMIT) && (rem == LEN_W'(1));
        tx_word       = orient(hold & mask, wl, lsb);
        idle          = (state == TX_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold <= '0;
            slot <= '0;
            rem  <= '0;
        end else begin
            if (begin_xfer) rem <= tx_count;
            if (take_fifo) begin
                hold <= tx_fifo_data;
                slot <= '0;
            end
            if (give_word) begin
                hold <= hold >> wl;
                slot <= slot + 6'd1;
                rem  <= rem - LEN_W'(1);
            end
        end
    end

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_word_valid && !tx_word_ready |=> tx_word_valid && $stable(tx_word)); // R11

    AST_TX_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tx_word_valid |-> ((tx_word & ~mask) == '0)); // R2

endmodule

// File: rtl/spw_rx_pack.sv
module spw_rx_pack
    import spw_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WLW-1:0]   wl,
    input  logic             lsb,
    input  logic [FW-1:0]    mask,
    input  logic             shared,
    input  logic [WLW-1:0]   per,
    input  logic [1:0]       lane_lbv,
    input  logic             rx_start,
    input  logic [LEN_W-1:0] rx_count,
    input  logic [FW-1:0]    rx_word,
    input  logic             rx_word_valid,
    output logic             rx_word_ready,
    output logic [FW-1:0]    rx_fifo_data,
    output logic             rx_fifo_valid,
    input  logic             rx_fifo_ready,
    output logic             rx_fifo_last,
    output logic [1:0]       rx_fifo_lbv,
    output logic [LEN_W-1:0] rx_fifo_cnt,
    output logic             idle
);

    rx_state_e        state, state_n;
    logic [FW-1:0]    acc;
    logic [WLW-1:0]   pos, slot;
    logic [LEN_W-1:0] rem, seq;
    logic             last_q;
    logic [1:0]       lbv_q;
    logic             begin_xfer, take_word, word_done, push_out;
    logic [WLW-1:0]   nbits;
    logic [FW-1:0]    aligned;

    assign begin_xfer = (state == RX_IDLE) && rx_start && (rx_count != '0);
    assign take_word  = (state == RX_FILL) && rx_word_valid;
    assign word_done  = (slot + 6'd1 == per) || (rem == LEN_W'(1));
    assign push_out   = (state == RX_FLUSH) && rx_fifo_ready;
    assign nbits      = pos + wl;
    assign aligned    = orient(rx_word & mask, wl, lsb) << pos;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            RX_IDLE:  if (begin_xfer)             state_n = RX_FILL;
            RX_FILL:  if (take_word && word_done) state_n = RX_FLUSH;
            RX_FLUSH: if (push_out)               state_n = last_q ? RX_IDLE : RX_FILL;
            default:                              state_n = RX_IDLE;
        endcase
    end

    always_comb begin
        rx_word_ready = (state == RX_FILL);
        rx_fifo_valid = (state == RX_FLUSH);
        rx_fifo_data  = acc;
        rx_fifo_last  = (state == RX_FLUSH) && last_q;
        rx_fifo_lbv   = lbv_q;
        rx_fifo_cnt   = seq;
        idle          = (state == RX_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc    <= '0;
            pos    <= '0;
            slot   <= '0;
            rem    <= '0;
            seq    <= '0;
            last_q <= 1'b0;
            lbv_q  <= 2'd0;
        end else begin
            if (begin_xfer) begin
                rem  <= rx_count;
                seq  <= '0;
                acc  <= '0;
                pos  <= '0;
                slot <= '0;
            end
            if (take_word) begin
                acc  <= acc | aligned;
                pos  <= nbits;
                slot <= slot + 6'd1;
                rem  <= rem - LEN_W'(1);
                if (word_done) begin
                    seq    <= seq + LEN_W'(1);
                    last_q <= (rem == LEN_W'(1));
                    if (rem != LEN_W'(1)) lbv_q <= 2'd0;
                    else if (shared)      lbv_q <= lbv_of_bits(nbits);
                    else                  lbv_q <= lane_lbv;
                end
            end
            if (push_out) begin
                acc  <= '0;
                pos  <= '0;
                slot <= '0;
            end
        end
    end

    AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fifo_valid && !rx_fifo_ready |=>
            rx_fifo_valid && $stable(rx_fifo_data) && $stable(rx_fifo_lbv)); // R11

    AST_RX_MID_LBV: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fifo_valid && !rx_fifo_last |-> (rx_fifo_lbv == 2'd0)); // R5

    AST_RX_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fifo_valid |-> (rx_fifo_cnt != '0)); // R8

endmodule

// File: rtl/spi_word_packer.sv
module spi_word_packer
    import spw_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int RST_WL = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [5:0]       cfg_word_len,
    input  logic             cfg_lsb_first,
    input  logic             tx_start,
    input  logic [LEN_W-1:0] tx_count,
    input  logic [31:0]      tx_fifo_data,
    input  logic             tx_fifo_valid,
    output logic             tx_fifo_ready,
    output logic [31:0]      tx_word,
    output logic             tx_word_valid,
    input  logic             tx_word_ready,
    output logic             tx_word_last,
    input  logic             rx_start,
    input  logic [LEN_W-1:0] rx_count,
    input  logic [31:0]      rx_word,
    input  logic             rx_word_valid,
    output logic             rx_word_ready,
    output logic [31:0]      rx_fifo_data,
    output logic             rx_fifo_valid,
    input  logic             rx_fifo_ready,
    output logic             rx_fifo_last,
    output logic [1:0]       rx_fifo_lbv,
    output logic [LEN_W-1:0] rx_fifo_cnt
);

    logic [WLW-1:0] wl, per;
    logic           lsb, shared;
    logic [FW-1:0]  mask;
    logic [1:0]     lane_lbv;
    logic           tx_idle, rx_idle;

    spw_cfg #(.RST_WL(RST_WL)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_word_len(cfg_word_len), .cfg_lsb_first(cfg_lsb_first),
        .tx_idle(tx_idle), .rx_idle(rx_idle),
        .wl(wl), .lsb(lsb), .mask(mask), .shared(shared), .per(per), .lane_lbv(lane_lbv)
    );

    spw_tx_unpack #(.LEN_W(LEN_W)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .wl(wl), .lsb(lsb), .mask(mask), .per(per),
        .tx_start(tx_start), .tx_count(tx_count),
        .tx_fifo_data(tx_fifo_data), .tx_fifo_valid(tx_fifo_valid), .tx_fifo_ready(tx_fifo_ready),
        .tx_word(tx_word), .tx_word_valid(tx_word_valid), .tx_word_ready(tx_word_ready),
        .tx_word_last(tx_word_last), .idle(tx_idle)
    );

    spw_rx_pack #(.LEN_W(LEN_W)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .wl(wl), .lsb(lsb), .mask(mask), .shared(shared), .per(per), .lane_lbv(lane_lbv),
        .rx_start(rx_start), .rx_count(rx_count),
        .rx_word(rx_word), .rx_word_valid(rx_word_valid), .rx_word_ready(rx_word_ready),
        .rx_fifo_data(rx_fifo_data), .rx_fifo_valid(rx_fifo_valid), .rx_fifo_ready(rx_fifo_ready),
        .rx_fifo_last(rx_fifo_last), .rx_fifo_lbv(rx_fifo_lbv), .rx_fifo_cnt(rx_fifo_cnt),
        .idle(rx_idle)
    );

    AST_TX_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_fifo_ready && tx_word_valid)); // R4

endmodule

// File: tb/spi_word_packer_test.sv
module spi_word_packer_test;

    localparam int LEN_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0, cfg_lsb_first = 1'b0;
    logic [5:0] cfg_word_len = 6'd8;
    logic tx_start = 1'b0, rx_start = 1'b0;
    logic [LEN_W-1:0] tx_count = '0, rx_count = '0;
    logic [31:0] tx_fifo_data = '0, rx_word = '0;
    logic tx_fifo_valid = 1'b0, tx_word_ready = 1'b0;
    logic rx_word_valid = 1'b0, rx_fifo_ready = 1'b0;
    logic tx_fifo_ready, tx_word_valid, tx_word_last;
    logic [31:0] tx_word, rx_fifo_data;
    logic rx_word_ready, rx_fifo_valid, rx_fifo_last;
    logic [1:0] rx_fifo_lbv;
    logic [LEN_W-1:0] rx_fifo_cnt;

    always #5 clk = ~clk;

    spi_word_packer #(.LEN_W(LEN_W)) uut (.*);

    int n_vec = 0, n_err = 0;
    int cur_wl = 8;
    bit cur_lsb = 1'b0;
    bit finished = 1'b0;
    logic [31:0] fw [64];
    logic [31:0] rw [64];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] b_mask(input int wl);
        if (wl >= 32) return 32'hFFFF_FFFF;
        return (32'd1 << wl) - 32'd1;
    endfunction

    function automatic logic [31:0] b_orient(input logic [31:0] v, input int wl, input bit lsb);
        logic [31:0] r = '0;
        if (!lsb) return v;
        for (int i = 0; i < wl; i++) r[wl-1-i] = v[i];
        return r;
    endfunction

    function automatic int b_per(input int wl);
        return (32 % wl == 0) ? 32 / wl : 1;
    endfunction

    function automatic int b_lane_bytes(input int wl);
        int b = 1;
        while (b * 8 < wl) b = b * 2;
        return b;
    endfunction

    task automatic do_cfg(input int wl, input bit lsb);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_word_len = wl[5:0]; cfg_lsb_first = lsb;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (wl >= 4 && wl <= 32) begin cur_wl = wl; cur_lsb = lsb; end
    endtask

    // poke: 0 none, 1 config write while busy (R9), 2 restart while busy (R10)
    task automatic run_tx(input int count, input int poke);
        int per = b_per(cur_wl);
        int nfifo = (count + per - 1) / per;
        int fi = 0, wo = 0, cyc = 0;
        bit stall = 1'b0;
        logic [31:0] prev = '0, expw;
        string tag;
        tag = cur_lsb ? "R3" : ((per > 1 || cur_wl == 32) ? "R1" : "R2");
        for (int i = 0; i < 64; i++) fw[i] = $urandom;
        @(negedge clk);
        tx_start = 1'b1; tx_count = count[LEN_W-1:0];
        @(negedge clk);
        tx_start = 1'b0;
        while (wo < count && cyc < 3000) begin
            tx_fifo_valid = ($urandom % 4) != 0;
            tx_fifo_data  = fw[fi];
            tx_word_ready = ($urandom % 3) != 0;
            cfg_wr   = (poke == 1 && cyc == 2);
            cfg_word_len = 6'd12; cfg_lsb_first = ~cur_lsb;
            tx_start = (poke == 2 && cyc == 2);
            tx_count = 16'd5;
            #1;
            if (stall) chk(tx_word_valid && tx_word == prev, "R11", tx_word, prev);
            if (tx_fifo_valid && tx_fifo_ready) fi++;
            if (tx_word_valid && tx_word_ready) begin
                expw = b_orient((fw[wo / per] >> ((wo % per) * cur_wl)) & b_mask(cur_wl), cur_wl, cur_lsb);
                chk(tx_word == expw, tag, tx_word, expw);
                chk(tx_word_last == (wo == count - 1), "R4", {31'd0, tx_word_last}, {31'd0, wo == count - 1});
                wo++;
            end
            stall = tx_word_valid && !tx_word_ready;
            prev = tx_word;
            cyc++;
            @(negedge clk);
        end
        tx_fifo_valid = 1'b0; tx_word_ready = 1'b0; cfg_wr = 1'b0; tx_start = 1'b0;
        chk(fi == nfifo, "R4", fi, nfifo);
        #1;
        chk(!tx_fifo_ready && !tx_word_valid, "R10", {30'd0, tx_fifo_ready, tx_word_valid}, 32'd0);
    endtask

    task automatic run_rx(input int count);
        int per = b_per(cur_wl);
        int nfifo = (count + per - 1) / per;
        int wi = 0, fo = 0, cyc = 0, k, bytes;
        bit stall = 1'b0, is_last;
        logic [31:0] prev = '0, expd;
        logic [1:0] explbv;
        string tag;
        for (int i = 0; i < 64; i++) rw[i] = $urandom;
        @(negedge clk);
        rx_start = 1'b1; rx_count = count[LEN_W-1:0];
        @(negedge clk);
        rx_start = 1'b0;
        while (fo < nfifo && cyc < 3000) begin
            rx_word_valid = ($urandom % 4) != 0;
            rx_word       = rw[wi];
            rx_fifo_ready = ($urandom % 3) != 0;
            #1;
            if (stall) chk(rx_fifo_valid && rx_fifo_data == prev, "R11", rx_fifo_data, prev);
            if (rx_word_valid && rx_word_ready) wi++;
            if (rx_fifo_valid && rx_fifo_ready) begin
                k = (count - fo * per < per) ? count - fo * per : per;
                expd = '0;
                for (int i = 0; i < k; i++)
                    expd = expd | (b_orient(rw[fo * per + i] & b_mask(cur_wl), cur_wl, cur_lsb) << (i * cur_wl));
                is_last = (fo == nfifo - 1);
                bytes = (per > 1 || cur_wl == 32) ? (k * cur_wl + 7) / 8 : b_lane_bytes(cur_wl);
                explbv = is_last ? 2'(bytes % 4) : 2'd0;
                tag = (k < per) ? "R7" : (cur_lsb ? "R3" : "R1");
                chk(rx_fifo_data == expd, tag, rx_fifo_data, expd);
                chk(rx_fifo_last == is_last, "R5", {31'd0, rx_fifo_last}, {31'd0, is_last});
                chk(rx_fifo_lbv == explbv, is_last ? "R6" : "R5", {30'd0, rx_fifo_lbv}, {30'd0, explbv});
                chk(rx_fifo_cnt == LEN_W'(fo + 1), "R8", {16'd0, rx_fifo_cnt}, fo + 1);
                fo++;
            end
            stall = rx_fifo_valid && !rx_fifo_ready;
            prev = rx_fifo_data;
            cyc++;
            @(negedge clk);
        end
        rx_word_valid = 1'b0; rx_fifo_ready = 1'b0;
        chk(fo == nfifo && wi == count, "R7", wi, count);
        #1;
        chk(!rx_word_ready && !rx_fifo_valid, "R5", {30'd0, rx_word_ready, rx_fifo_valid}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!tx_fifo_ready && !tx_word_valid && !rx_word_ready && !rx_fifo_valid, "R12",
            {28'd0, tx_fifo_ready, tx_word_valid, rx_word_ready, rx_fifo_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!tx_fifo_ready && !tx_word_valid && !rx_word_ready && !rx_fifo_valid, "R12",
            {28'd0, tx_fifo_ready, tx_word_valid, rx_word_ready, rx_fifo_valid}, 32'd0);
        // R12: default length 8, most significant first
        run_tx(6, 0);
        run_rx(5);

        // R1 shared lengths with boundary counts
        do_cfg(4, 0);  run_tx(8, 0); run_tx(9, 0); run_rx(3); run_rx(8);
        do_cfg(16, 0); run_tx(1, 0); run_tx(3, 0); run_rx(3);
        do_cfg(32, 1); run_tx(4, 0); run_rx(2);
        do_cfg(8, 1);  run_tx(7, 0); run_rx(6);
        // R2 / R6 unshared lengths
        do_cfg(5, 0);  run_tx(4, 0); run_rx(3);
        do_cfg(12, 1); run_tx(4, 0); run_rx(3);
        do_cfg(24, 0); run_tx(3, 0); run_rx(2);
        do_cfg(31, 1); run_tx(3, 0); run_rx(2);

        // R9: writes while busy or out of range are ignored
        do_cfg(8, 0);
        run_tx(10, 1);
        run_rx(5);
        do_cfg(3, 1);  run_tx(5, 0); run_rx(5);
        do_cfg(33, 1); run_tx(5, 0); run_rx(6);

        // R10: restart while busy ignored, zero count ignored
        run_tx(9, 2);
        @(negedge clk);
        tx_start = 1'b1; tx_count = '0; rx_start = 1'b1; rx_count = '0;
        @(negedge clk);
        tx_start = 1'b0; rx_start = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk(!tx_fifo_ready && !rx_word_ready, "R10", {30'd0, tx_fifo_ready, rx_word_ready}, 32'd0);

        // random lengths and orders
        for (int it = 0; it < 30; it++) begin
            do_cfg(4 + int'($urandom % 29), bit'($urandom % 2));
            run_tx(1 + int'($urandom % 20), 0);
            run_rx(1 + int'($urandom % 20));
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

endmodule